// File: doc/BRIEF.md
# CPU-Port Management Tag Inserter and Checker

This block sits on the CPU-facing port of an Ethernet switch. It carries two independent byte-wide AXI4-Stream paths. On the transmit path, every frame the CPU sends toward the switch gets a 16-bit management tag in front of it. The tag names the egress port chosen by the CPU. On the receive path, the tag the switch prepends to each frame is read, checked and removed. The source port, priority, type and broadcast flag it carries are presented as sideband signals next to the payload.

The tag is sent low byte first. In tag bit terms, bits 15:14 hold a version that must equal 1. Bits 13:12 hold a priority and bits 10:8 a type. Bit 7 marks broadcast and bit 6 marks a frame that came from the CPU. Bits 5:4 are a reserved pair and bits 3:0 are a port number.

A received frame is discarded when its tag is malformed or when the frame is too short to carry a tag and at least one payload byte. A discarded frame is still drained from the input up to its last beat, so the upstream side never stalls on it.

Top module: `hdr_tag_port`

## Requirements
- R1: The first transmit output beat of every frame is the tag low byte: bit 7 (broadcast) = 0, bit 6 (from CPU) = 1, bits 5:4 = 2'b11, bits 3:0 = `tx_dest_port`. This is 8'h70 | port.
- R2: The second transmit output beat of every frame is the tag high byte: bits 7:6 = 2'b01 (version 1), priority = 0, bit 3 = 0, type = 0. This is 8'h40.
- R3: While the two tag bytes are being emitted, `tx_s_tready` is low. After them, the input frame passes unchanged, with `tx_m_tlast` on its final byte only.
- R4: Back-to-back transmit frames each receive their own tag, with no beats lost between them.
- R5: The receive path removes the first two bytes of an accepted frame and forwards the remaining bytes unchanged, with `rx_m_tlast` on the last one.
- R6: For an accepted frame, the sideband outputs are valid from the first payload beat and constant until its last beat. `rx_src_port` comes from byte 0 bits 3:0, `rx_bcast` from byte 0 bit 7, `rx_prio` from byte 1 bits 5:4, and `rx_type` from byte 1 bits 2:0.
- R7: A received frame whose byte 1 bits 7:6 differ from 2'b01 produces no output beat and is drained up to its tlast.
- R8: A received frame whose byte 0 bit 6 is set produces no output beat and is drained up to its tlast.
- R9: A received frame of one or two bytes produces no output beat.
- R10: After reset, both `tx_m_tvalid` and `rx_m_tvalid` are low and `rx_s_tready` is high. A reset in the middle of a received frame leaves the next frame parsed correctly.
- R11: While an output tvalid is high and its tready is low, tvalid stays high and tdata does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_s_tdata | input | 8 | CPU frame byte |
| tx_s_tvalid | input | 1 | CPU frame byte valid |
| tx_s_tready | output | 1 | CPU frame byte accepted |
| tx_s_tlast | input | 1 | Last byte of CPU frame |
| tx_dest_port | input | 4 | Egress port, held stable for the frame |
| tx_m_tdata | output | 8 | Tagged frame byte toward switch |
| tx_m_tvalid | output | 1 | Tagged byte valid |
| tx_m_tready | input | 1 | Switch accepts byte |
| tx_m_tlast | output | 1 | Last byte of tagged frame |
| rx_s_tdata | input | 8 | Tagged byte from switch |
| rx_s_tvalid | input | 1 | Tagged byte valid |
| rx_s_tready | output | 1 | Tagged byte accepted |
| rx_s_tlast | input | 1 | Last byte of tagged frame |
| rx_m_tdata | output | 8 | Payload byte toward CPU |
| rx_m_tvalid | output | 1 | Payload byte valid |
| rx_m_tready | input | 1 | CPU accepts byte |
| rx_m_tlast | output | 1 | Last payload byte |
| rx_src_port | output | 4 | Source port of current frame |
| rx_prio | output | 2 | Priority of current frame |
| rx_type | output | 3 | Type of current frame |
| rx_bcast | output | 1 | Broadcast flag of current frame |

## Verification
The tag layout is fixed by the wire format, so the bench builds the block with its default package widths. Those widths give an 8-bit beat, a 4-bit port, a 2-bit priority and a 3-bit type. At these values a few hand-picked header bytes reach every case that matters. They cover all four version codes, the from-CPU bit, the reserved bit 11 set and clear, the all-ones port and type, and payload lengths of one to three bytes. They also cover the one- and two-byte short frames at the edge of the minimum length. Ready toggling on both output sides exercises the stall behaviour around the header beats.

// File: rtl/hdr_tag_pkg.sv
package hdr_tag_pkg;
  localparam int BYTE_W = 8;
  localparam int PORT_W = 4;
  localparam int PRIO_W = 2;
  localparam int TYPE_W = 3;
  localparam int TAG_W  = 2 * BYTE_W;
  localparam logic [1:0] TAG_VERSION = 2'b01;
  localparam logic [1:0] TAG_RSV_TX  = 2'b11;

  typedef struct packed {
    logic [1:0]        ver;
    logic [PRIO_W-1:0] prio;
    logic              rsv_hi;
    logic [TYPE_W-1:0] kind;
    logic              bcast;
    logic              from_cpu;
    logic [1:0]        rsv_lo;
    logic [PORT_W-1:0] port;
  } tag_t;

  typedef enum logic [1:0] {TX_LO, TX_HI, TX_BODY} tx_st_e;
  typedef enum logic [1:0] {RX_LO, RX_HI, RX_PASS, RX_DROP} rx_st_e;
endpackage

// File: rtl/tag_tx_insert.sv
module tag_tx_insert
  import hdr_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic [PORT_W-1:0] dest_port,
  output logic [BYTE_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  tx_st_e st_q, st_d;
  tag_t   tag;

  always_comb begin
    tag          = '0;
    tag.ver      = TAG_VERSION;
    tag.from_cpu = 1'b1;
    tag.rsv_lo   = TAG_RSV_TX;
    tag.port     = dest_port;
  end

  always_comb begin
    st_d     = st_q;
    s_tready = 1'b0;
    m_tvalid = 1'b0;
    m_tlast  = 1'b0;
    m_tdata  = s_tdata;
    case (st_q)
      TX_LO: begin
        m_tvalid = s_tvalid;
        m_tdata  = tag[BYTE_W-1:0];
        if (s_tvalid && m_tready) st_d = TX_HI;
      end
      TX_HI: begin
        m_tvalid = 1'b1;
        m_tdata  = tag[TAG_W-1:BYTE_W];
        if (m_tready) st_d = TX_BODY;
      end
      default: begin
        m_tvalid = s_tvalid;
        s_tready = m_tready;
        m_tlast  = s_tlast;
        if (s_tvalid && m_tready && s_tlast) st_d = TX_LO;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TX_LO;
    else        st_q <= st_d;
  end

  // checker state: where the output stream is within a frame
  logic m_fire, s_fire, sof_q, snd_q;
  assign m_fire = m_tvalid && m_tready;
  assign s_fire = s_tvalid && s_tready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q <= 1'b1;
      snd_q <= 1'b0;
    end else if (m_fire) begin
      sof_q <= m_tlast;
      snd_q <= sof_q;
    end
  end

  assert_tag_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fire && sof_q) |-> (m_tdata == {4'h7, dest_port} && !m_tlast));
  assert_tag_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fire && snd_q) |-> (m_tdata == 8'h40 && !m_tlast));
  assert_no_intake_in_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_q || snd_q) |-> !s_fire);
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
endmodule

// File: rtl/tag_rx_strip.sv
module tag_rx_strip
  import hdr_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [BYTE_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic [PORT_W-1:0] src_port,
  output logic [PRIO_W-1:0] prio,
  output logic [TYPE_W-1:0] kind,
  output logic              bcast
);
  rx_st_e            st_q, st_d;
  logic [BYTE_W-1:0] lo_q;
  logic              lo_en, side_en, hdr_ok;
  tag_t              tag;

  assign tag    = {s_tdata, lo_q};
  assign hdr_ok = (tag.ver == TAG_VERSION) && !tag.from_cpu;

  always_comb begin
    st_d     = st_q;
    lo_en    = 1'b0;
    side_en  = 1'b0;
    s_tready = 1'b1;
    m_tvalid = 1'b0;
    m_tlast  = 1'b0;
    m_tdata  = s_tdata;
    case (st_q)
      RX_LO: begin
        if (s_tvalid) begin
          lo_en = 1'b1;
          if (!s_tlast) st_d = RX_HI;
        end
      end
      RX_HI: begin
        if (s_tvalid) begin
          if (s_tlast) st_d = RX_LO;
          else if (hdr_ok) begin
            side_en = 1'b1;
            st_d    = RX_PASS;
          end else st_d = RX_DROP;
        end
      end
      RX_PASS: begin
        m_tvalid = s_tvalid;
        s_tready = m_tready;
        m_tlast  = s_tlast;
        if (s_tvalid && m_tready && s_tlast) st_d = RX_LO;
      end
      default: begin
        if (s_tvalid && s_tlast) st_d = RX_LO;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_LO;
      lo_q     <= '0;
      src_port <= '0;
      prio     <= '0;
      kind     <= '0;
      bcast    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (lo_en) lo_q <= s_tdata;
      if (side_en) begin
        src_port <= tag.port;
        prio     <= tag.prio;
        kind     <= tag.kind;
        bcast    <= tag.bcast;
      end
    end
  end

  // checker: independent record of the first two input bytes of a frame
  logic [1:0]        beat_q;
  logic [BYTE_W-1:0] chk_lo_q, chk_hi_q;
  logic              s_fire;
  assign s_fire = s_tvalid && s_tready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= 2'd0;
      chk_lo_q <= '0;
      chk_hi_q <= '0;
    end else if (s_fire) begin
      if (beat_q == 2'd0) chk_lo_q <= s_tdata;
      if (beat_q == 2'd1) chk_hi_q <= s_tdata;
      if (s_tlast)             beat_q <= 2'd0;
      else if (beat_q != 2'd2) beat_q <= beat_q + 2'd1;
    end
  end

  assert_payload_after_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (beat_q == 2'd2));
  assert_side_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (src_port == chk_lo_q[3:0] && bcast == chk_lo_q[7] &&
                  prio == chk_hi_q[5:4] && kind == chk_hi_q[2:0]));
  assert_bad_version_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (chk_hi_q[7:6] == 2'b01));
  assert_from_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !chk_lo_q[6]);
  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));
endmodule

// File: rtl/hdr_tag_port.sv
module hdr_tag_port
  import hdr_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_s_tdata,
  input  logic              tx_s_tvalid,
  output logic              tx_s_tready,
  input  logic              tx_s_tlast,
  input  logic [PORT_W-1:0] tx_dest_port,
  output logic [BYTE_W-1:0] tx_m_tdata,
  output logic              tx_m_tvalid,
  input  logic              tx_m_tready,
  output logic              tx_m_tlast,
  input  logic [BYTE_W-1:0] rx_s_tdata,
  input  logic              rx_s_tvalid,
  output logic              rx_s_tready,
  input  logic              rx_s_tlast,
  output logic [BYTE_W-1:0] rx_m_tdata,
  output logic              rx_m_tvalid,
  input  logic              rx_m_tready,
  output logic              rx_m_tlast,
  output logic [PORT_W-1:0] rx_src_port,
  output logic [PRIO_W-1:0] rx_prio,
  output logic [TYPE_W-1:0] rx_type,
  output logic              rx_bcast
);
  tag_tx_insert u_tx (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(tx_s_tdata), .s_tvalid(tx_s_tvalid), .s_tready(tx_s_tready), .s_tlast(tx_s_tlast),
    .dest_port(tx_dest_port),
    .m_tdata(tx_m_tdata), .m_tvalid(tx_m_tvalid), .m_tready(tx_m_tready), .m_tlast(tx_m_tlast)
  );

  tag_rx_strip u_rx (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(rx_s_tdata), .s_tvalid(rx_s_tvalid), .s_tready(rx_s_tready), .s_tlast(rx_s_tlast),
    .m_tdata(rx_m_tdata), .m_tvalid(rx_m_tvalid), .m_tready(rx_m_tready), .m_tlast(rx_m_tlast),
    .src_port(rx_src_port), .prio(rx_prio), .kind(rx_type), .bcast(rx_bcast)
  );
endmodule

// File: tb/hdr_tag_port_bench.sv
module hdr_tag_port_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [7:0] tx_s_tdata, tx_m_tdata, rx_s_tdata, rx_m_tdata;
  logic       tx_s_tvalid, tx_s_tready, tx_s_tlast, tx_m_tvalid, tx_m_tready, tx_m_tlast;
  logic       rx_s_tvalid, rx_s_tready, rx_s_tlast, rx_m_tvalid, rx_m_tready, rx_m_tlast;
  logic [3:0] tx_dest_port, rx_src_port;
  logic [1:0] rx_prio;
  logic [2:0] rx_type;
  logic       rx_bcast;

  hdr_tag_port u_hdr_tag_port (.*);

  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // capture at the falling edge, beats that handshake at the next rising edge
  logic [7:0] rcap_d [0:31];
  bit         rcap_l [0:31];
  logic [3:0] rcap_p [0:31];
  logic [1:0] rcap_r [0:31];
  logic [2:0] rcap_t [0:31];
  bit         rcap_b [0:31];
  int         rcnt = 0;
  logic [7:0] tcap_d [0:31];
  bit         tcap_l [0:31];
  int         tcnt = 0;
  bit         rx_pend = 0, tx_pend = 0;
  logic [7:0] rx_pd, tx_pd;

  always @(negedge clk) begin
    if (!rst_n) begin
      rx_pend = 0;
      tx_pend = 0;
    end else begin
      if (rx_pend) chk(rx_m_tvalid && rx_m_tdata == rx_pd, "R11 rx hold", int'(rx_m_tdata), int'(rx_pd));
      if (tx_pend) chk(tx_m_tvalid && tx_m_tdata == tx_pd, "R11 tx hold", int'(tx_m_tdata), int'(tx_pd));
      rx_pend = rx_m_tvalid && !rx_m_tready;
      rx_pd   = rx_m_tdata;
      tx_pend = tx_m_tvalid && !tx_m_tready;
      tx_pd   = tx_m_tdata;
      if (rx_m_tvalid && rx_m_tready && rcnt < 32) begin
        rcap_d[rcnt] = rx_m_tdata; rcap_l[rcnt] = rx_m_tlast;
        rcap_p[rcnt] = rx_src_port; rcap_r[rcnt] = rx_prio;
        rcap_t[rcnt] = rx_type; rcap_b[rcnt] = rx_bcast;
        rcnt++;
      end
      if (tx_m_tvalid && tx_m_tready && tcnt < 32) begin
        tcap_d[tcnt] = tx_m_tdata; tcap_l[tcnt] = tx_m_tlast;
        tcnt++;
      end
    end
  end

  task automatic rx_beat(input logic [7:0] d, input bit last);
    bit ok;
    rx_s_tdata = d; rx_s_tlast = last; rx_s_tvalid = 1'b1;
    do begin
      @(negedge clk); ok = rx_s_tready;
      @(posedge clk); #1;
    end while (!ok);
    rx_s_tvalid = 1'b0; rx_s_tlast = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b [0:7], input int n);
    for (int i = 0; i < n; i++) rx_beat(b[i], i == n - 1);
  endtask

  task automatic tx_send(input logic [7:0] b [0:7], input int n, input logic [3:0] port);
    bit ok;
    tx_dest_port = port;
    for (int i = 0; i < n; i++) begin
      tx_s_tdata = b[i]; tx_s_tlast = (i == n - 1); tx_s_tvalid = 1'b1;
      do begin
        @(negedge clk); ok = tx_s_tready;
        @(posedge clk); #1;
      end while (!ok);
    end
    tx_s_tvalid = 1'b0; tx_s_tlast = 1'b0;
  endtask

  // {byte0, byte1, keep, port, prio, type, bcast, 5'b0}
  localparam logic [31:0] VEC [0:7] = '{
    32'h3563_ACC0, 32'hB27F_97E0, 32'h0040_8000, 32'h3180_0000,
    32'h3100_0000, 32'h7140_0000, 32'h3FC1_0000, 32'h8F51_FA60
  };

  initial begin
    logic [7:0] fr [0:7];
    logic [7:0] fa [0:7];
    logic [7:0] fb [0:7];
    logic [7:0] exp_tx [0:8];
    bit done;
    rst_n = 1'b0;
    tx_s_tdata = '0; tx_s_tvalid = 0; tx_s_tlast = 0; tx_dest_port = '0; tx_m_tready = 1;
    rx_s_tdata = '0; rx_s_tvalid = 0; rx_s_tlast = 0; rx_m_tready = 1;
    for (int i = 0; i < 8; i++) begin fr[i] = '0; fa[i] = '0; fb[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk(!tx_m_tvalid, "R10 tx_m_tvalid after reset", int'(tx_m_tvalid), 0);
    chk(!rx_m_tvalid, "R10 rx_m_tvalid after reset", int'(rx_m_tvalid), 0);
    chk(rx_s_tready, "R10 rx_s_tready after reset", int'(rx_s_tready), 1);
    @(posedge clk); #1;

    // vector table: receive parsing, stripping and dropping
    for (int v = 0; v < 8; v++) begin
      int plen;
      plen = 1 + (v % 3);
      fr[0] = VEC[v][31:24];
      fr[1] = VEC[v][23:16];
      for (int k = 0; k < plen; k++) fr[2+k] = 8'(v * 16 + k + 1);
      rcnt = 0;
      rx_send(fr, plen + 2);
      repeat (3) @(negedge clk);
      @(posedge clk); #1;
      if (VEC[v][15]) begin
        chk(rcnt == plen, "R5 payload beat count", rcnt, plen);
        for (int k = 0; k < plen && k < rcnt; k++) begin
          chk(rcap_d[k] == 8'(v * 16 + k + 1), "R5 payload byte", int'(rcap_d[k]), v * 16 + k + 1);
          chk(rcap_l[k] == (k == plen - 1), "R5 tlast position", int'(rcap_l[k]), int'(k == plen - 1));
          chk(rcap_p[k] == VEC[v][14:11] && rcap_r[k] == VEC[v][10:9] &&
              rcap_t[k] == VEC[v][8:6] && rcap_b[k] == VEC[v][5],
              "R6 sideband", int'({rcap_p[k], rcap_r[k], rcap_t[k], rcap_b[k]}), int'(VEC[v][14:5]));
        end
      end else begin
        chk(rcnt == 0, "R7 R8 malformed tag dropped", rcnt, 0);
      end
    end

    // R9 short frames, then a good frame proves they were drained
    rcnt = 0;
    fr[0] = 8'h35; rx_send(fr, 1);
    fr[0] = 8'h35; fr[1] = 8'h40; rx_send(fr, 2);
    repeat (3) @(negedge clk);
    chk(rcnt == 0, "R9 one and two byte frames dropped", rcnt, 0);
    @(posedge clk); #1;
    fr[0] = 8'h34; fr[1] = 8'h40; fr[2] = 8'hDE; fr[3] = 8'hAD;
    rx_send(fr, 4);
    repeat (3) @(negedge clk);
    chk(rcnt == 2 && rcap_d[0] == 8'hDE && rcap_d[1] == 8'hAD && rcap_l[1],
        "R9 frame after short frames", rcnt, 2);
    chk(rcap_p[0] == 4'h4, "R6 port after short frames", int'(rcap_p[0]), 4);
    @(posedge clk); #1;

    // R11 receive backpressure
    rcnt = 0; done = 0;
    fr[0] = 8'h23; fr[1] = 8'h40;
    for (int k = 0; k < 5; k++) fr[2+k] = 8'hA0 + 8'(k);
    fork
      begin rx_send(fr, 7); done = 1; end
      begin
        while (!done) begin @(posedge clk); #2; rx_m_tready = ~rx_m_tready; end
        rx_m_tready = 1;
      end
    join
    repeat (4) @(negedge clk);
    chk(rcnt == 5, "R11 rx beats under backpressure", rcnt, 5);
    for (int k = 0; k < 5 && k < rcnt; k++)
      chk(rcap_d[k] == 8'hA0 + 8'(k) && rcap_l[k] == (k == 4), "R11 rx byte under backpressure",
          int'(rcap_d[k]), int'(8'hA0 + 8'(k)));
    @(posedge clk); #1;

    // R3 and R1: tag low byte presented while input is held off
    tcnt = 0;
    fa[0] = 8'hAA; fa[1] = 8'hBB; fa[2] = 8'hCC; fa[3] = 8'hDD;
    fb[0] = 8'h5A;
    tx_m_tready = 0; tx_dest_port = 4'd9;
    tx_s_tdata = fa[0]; tx_s_tlast = 0; tx_s_tvalid = 1;
    repeat (2) @(negedge clk);
    chk(!tx_s_tready, "R3 input stalled during tag", int'(tx_s_tready), 0);
    chk(tx_m_tvalid && tx_m_tdata == 8'h79, "R1 tag low byte shown first", int'(tx_m_tdata), 8'h79);
    @(posedge clk); #1;

    // R4 back-to-back transmit frames with toggling ready
    done = 0;
    fork
      begin tx_send(fa, 4, 4'd9); tx_send(fb, 1, 4'd12); done = 1; end
      begin
        tx_m_tready = 1;
        while (!done) begin @(posedge clk); #2; tx_m_tready = ~tx_m_tready; end
        tx_m_tready = 1;
      end
    join
    repeat (4) @(negedge clk);
    exp_tx = '{8'h79, 8'h40, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h7C, 8'h40, 8'h5A};
    chk(tcnt == 9, "R4 transmit beat count", tcnt, 9);
    for (int k = 0; k < 9 && k < tcnt; k++) begin
      chk(tcap_d[k] == exp_tx[k], (k == 0 || k == 6) ? "R1 tag low byte" :
          (k == 1 || k == 7) ? "R2 tag high byte" : "R3 payload unchanged",
          int'(tcap_d[k]), int'(exp_tx[k]));
      chk(tcap_l[k] == (k == 5 || k == 8), "R3 tx tlast position", int'(tcap_l[k]), int'(k == 5 || k == 8));
    end
    @(posedge clk); #1;

    // R10 reset in the middle of a received frame
    rx_beat(8'h31, 0); rx_beat(8'h40, 0); rx_beat(8'h99, 0);
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    rcnt = 0;
    fr[0] = 8'h12; fr[1] = 8'h40; fr[2] = 8'h77;
    rx_send(fr, 3);
    repeat (3) @(negedge clk);
    chk(rcnt == 1 && rcap_d[0] == 8'h77 && rcap_l[0], "R10 frame after mid-frame reset", rcnt, 1);
    chk(rcap_p[0] == 4'h2, "R10 port after mid-frame reset", int'(rcap_p[0]), 2);

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule